// File: doc/BRIEF.md
# External Interrupt Detection Unit

This block watches a set of external request lines, one per channel, and turns activity on them into interrupt requests. Each channel is configured on its own to react to a high level, a low level, a rising edge or a falling edge. Inputs are first synchronised to the block clock. Detected requests are held in a request register and gated by a per-channel mask, and each channel drives its own interrupt output.

Software uses a small 32-bit register bus with a single-cycle write and a combinational read. Through it, software sets the mask and trigger controls. It can read pending requests either before or after masking, and it retires requests by writing ones to a clear register. The trigger code of a channel is split over two registers: a polarity bit and an edge-select bit. A source-select word is stored and read back but drives no logic here.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, the mask register reads all ones, the polarity and edge registers read all ones (every channel set to rising edge), source select reads zero, raw and masked status read zero, and every interrupt output is low.
- R2: Word registers sit at byte offsets 0x00 (mask), 0x04 (source select), 0x14 (polarity), 0x18 (edge select). They are written when `bus_we` is high at a clock edge and read back combinationally. Offsets 0x10 and 0x1C, and any bit above the channel count, read as zero.
- R3: With polarity=1 and edge=1 (code 11), a rising input sets the channel's raw request bit on the third clock edge after the input changes. The bit stays set after the input falls again.
- R4: With polarity=0 and edge=1 (code 01), a falling input sets the request, and a rising input does not.
- R5: With edge=0, the request follows the synchronised input: active-high when polarity=1 (code 10), active-low when polarity=0 (code 00). The request drops when the level goes inactive.
- R6: Writing a 1 to a bit at offset 0x10 clears that channel's latched edge request on the next edge. Writing a 0 leaves the bit unchanged.
- R7: A level-mode request cleared while its level is still active reads zero for one cycle and is set again on the following edge.
- R8: A mask bit of 1 blocks the channel. The interrupt output and the masked status at 0x08 equal the request AND the inverted mask. The raw status at 0x0C shows requests whatever the mask.
- R9: Changing a channel's polarity or edge bit while its input is steady creates no edge request.
- R10: Channels are independent. Activity on or a clear of one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NCH | Asynchronous external request lines |
| bus_addr | input | AW | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | NCH | Per-channel interrupt outputs |

## Verification
All four trigger codes are driven with both input directions. This shows that each code reacts only to its own polarity: a rising line in falling-edge mode, for instance, must stay silent. Level channels are then released to show that they follow the line, while edge channels are released to show that they hold their request. Clears are sent as a targeted one, as an all-but-one word and as a clear of a still-active level, which separates clear-on-one from clear-on-write and shows the level re-arming. Configuration is also changed on steady inputs, and two channels are driven at the same moment, to expose spurious requests and crosstalk.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

    // word indices (byte offset / 4); order matters to the bus decoder
    localparam logic [2:0] WI_MASK  = 3'd0;
    localparam logic [2:0] WI_SRC   = 3'd1;
    localparam logic [2:0] WI_MSTAT = 3'd2;
    localparam logic [2:0] WI_RSTAT = 3'd3;
    localparam logic [2:0] WI_CLR   = 3'd4;
    localparam logic [2:0] WI_POL   = 3'd5;
    localparam logic [2:0] WI_EDG   = 3'd6;

    localparam int unsigned BUS_W = 32;

    // {polarity, edge} trigger code
    typedef enum logic [1:0] {
        TRIG_LVL_LOW   = 2'b00,
        TRIG_EDGE_FALL = 2'b01,
        TRIG_LVL_HIGH  = 2'b10,
        TRIG_EDGE_RISE = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
    parameter int unsigned NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pins_i,
    output logic [NCH-1:0] sync_o,
    output logic [NCH-1:0] prev_o
);

    typedef struct packed {
        logic [NCH-1:0] meta;
        logic [NCH-1:0] stab;
        logic [NCH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pins_i;
        st_d.stab = st_q.meta;
        st_d.prev = st_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stab;
    assign prev_o = st_q.prev;

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(sync_o)));

endmodule

// File: rtl/eiu_detect.sv
module eiu_detect
    import eiu_pkg::*;
#(
    parameter int unsigned NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sync_i,
    input  logic [NCH-1:0] prev_i,
    input  logic [NCH-1:0] pol_i,
    input  logic [NCH-1:0] edge_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] req_o
);

    typedef struct packed {
        logic [NCH-1:0] req;
    } det_t;

    det_t st_d, st_q;
    logic [NCH-1:0] lvl_act;
    logic [NCH-1:0] edg_hit;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NCH; k++) begin
            lvl_act[k] = 1'b0;
            edg_hit[k] = 1'b0;
            unique case (trig_mode_e'({pol_i[k], edge_i[k]}))
                TRIG_LVL_LOW:   lvl_act[k] = ~sync_i[k];
                TRIG_LVL_HIGH:  lvl_act[k] =  sync_i[k];
                TRIG_EDGE_FALL: edg_hit[k] = ~sync_i[k] &  prev_i[k];
                TRIG_EDGE_RISE: edg_hit[k] =  sync_i[k] & ~prev_i[k];
                default: ;
            endcase
            if (edge_i[k])
                st_d.req[k] = edg_hit[k] | (st_q.req[k] & ~clr_i[k]);
            else
                st_d.req[k] = lvl_act[k] & ~clr_i[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    // R9
    no_spurious_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_o & ~$past(req_o) & $past(edge_i) & ~$past(sync_i ^ prev_i)) == '0));

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_o & $past(clr_i & ~edg_hit & edge_i)) == '0));

    // R7
    level_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_o & $past(lvl_act & ~clr_i)) == $past(lvl_act & ~clr_i)));

endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
    import eiu_pkg::*;
#(
    parameter int unsigned NCH = 32,
    parameter int unsigned AW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NCH-1:0]   req_i,
    output logic [NCH-1:0]   mask_o,
    output logic [NCH-1:0]   pol_o,
    output logic [NCH-1:0]   edge_o,
    output logic [NCH-1:0]   clr_o
);

    localparam int unsigned WIDX_W = AW - 2;

    typedef struct packed {
        logic [NCH-1:0] mask;
        logic [NCH-1:0] src;
        logic [NCH-1:0] pol;
        logic [NCH-1:0] edg;
    } regs_t;

    regs_t st_d, st_q;
    logic [WIDX_W-1:0] widx;
    logic [NCH-1:0]    wbits;
    logic              unused_lsb;

    assign widx       = bus_addr[AW-1:2];
    assign wbits      = bus_wdata[NCH-1:0];
    assign unused_lsb = ^bus_addr[1:0];

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (bus_we) begin
            if (widx == WIDX_W'(WI_MASK)) st_d.mask = wbits;
            if (widx == WIDX_W'(WI_SRC))  st_d.src  = wbits;
            if (widx == WIDX_W'(WI_POL))  st_d.pol  = wbits;
            if (widx == WIDX_W'(WI_EDG))  st_d.edg  = wbits;
            if (widx == WIDX_W'(WI_CLR))  clr_o     = wbits;
        end
        bus_rdata = '0;
        if (widx == WIDX_W'(WI_MASK))  bus_rdata[NCH-1:0] = st_q.mask;
        if (widx == WIDX_W'(WI_SRC))   bus_rdata[NCH-1:0] = st_q.src;
        if (widx == WIDX_W'(WI_MSTAT)) bus_rdata[NCH-1:0] = req_i & ~st_q.mask;
        if (widx == WIDX_W'(WI_RSTAT)) bus_rdata[NCH-1:0] = req_i;
        if (widx == WIDX_W'(WI_POL))   bus_rdata[NCH-1:0] = st_q.pol;
        if (widx == WIDX_W'(WI_EDG))   bus_rdata[NCH-1:0] = st_q.edg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.src  <= '0;
            st_q.pol  <= '1;
            st_q.edg  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign pol_o  = st_q.pol;
    assign edge_o = st_q.edg;

    // R1
    reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_o == '1 && pol_o == '1 && edge_o == '1));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && widx == WIDX_W'(WI_POL)) |=> (pol_o == $past(wbits)));

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import eiu_pkg::*;
#(
    parameter int unsigned NCH = 32,
    parameter int unsigned AW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pins_i,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic [NCH-1:0]   irq_o
);

    logic [NCH-1:0] sync_w, prev_w, pol_w, edge_w, clr_w, req_w, mask_w;

    eiu_sync #(.NCH(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
        .sync_o(sync_w), .prev_o(prev_w)
    );

    eiu_detect #(.NCH(NCH)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .prev_i(prev_w),
        .pol_i(pol_w), .edge_i(edge_w), .clr_i(clr_w), .req_o(req_w)
    );

    eiu_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_i(req_w),
        .mask_o(mask_w), .pol_o(pol_w), .edge_o(edge_w), .clr_o(clr_w)
    );

    assign irq_o = req_w & ~mask_w;

    // R8
    mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[AW-1:2] == (AW-2)'(WI_MASK)) |=>
            ((irq_o & $past(bus_wdata[NCH-1:0])) == '0));

endmodule

// File: tb/sim_ext_irq_unit.sv
module sim_ext_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] pol_v = '1;
    logic [31:0] edg_v = '1;

    always #10 clk = ~clk;

    ext_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic [4:0] a, input int ch, input logic exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, {31'b0, d[ch]}, {31'b0, exp});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(5'h00, d); chk("R1 mask", d, 32'hFFFF_FFFF);
        rd(5'h14, d); chk("R1 pol", d, 32'hFFFF_FFFF);
        rd(5'h18, d); chk("R1 edge", d, 32'hFFFF_FFFF);
        rd(5'h04, d); chk("R1 src", d, 32'h0);
        rd(5'h0C, d); chk("R1 raw", d, 32'h0);
        rd(5'h08, d); chk("R1 masked", d, 32'h0);
        chk("R1 irq", irq, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(5'h04, 32'h1234_5678);
        rd(5'h04, d); chk("R2 src readback", d, 32'h1234_5678);
        wr(5'h00, 32'h0);
        rd(5'h00, d); chk("R2 mask readback", d, 32'h0);
        rd(5'h10, d); chk("R2 clear reads zero", d, 32'h0);
        rd(5'h1C, d); chk("R2 spare reads zero", d, 32'h0);
    endtask

    task automatic t_rise;
        pins[3] = 1'b1;
        tick(2);
        chk_bit("R3 not yet after 2 edges", 5'h0C, 3, 1'b0);
        tick(1);
        chk_bit("R3 set after 3 edges", 5'h0C, 3, 1'b1);
        chk("R3 irq", {31'b0, irq[3]}, 32'h1);
        pins[3] = 1'b0;
        tick(4);
        chk_bit("R3 held after fall", 5'h0C, 3, 1'b1);
        wr(5'h10, 32'hFFFF_FFF7);
        chk_bit("R6 zero write keeps", 5'h0C, 3, 1'b1);
        wr(5'h10, 32'h0000_0008);
        chk_bit("R6 one write clears", 5'h0C, 3, 1'b0);
    endtask

    task automatic t_fall;
        pol_v[5] = 1'b0;
        wr(5'h14, pol_v);
        tick(3);
        chk_bit("R9 pol change no req", 5'h0C, 5, 1'b0);
        pins[5] = 1'b1;
        tick(4);
        chk_bit("R4 rise ignored", 5'h0C, 5, 1'b0);
        pins[5] = 1'b0;
        tick(3);
        chk_bit("R4 fall detected", 5'h0C, 5, 1'b1);
        wr(5'h10, 32'h0000_0020);
        chk_bit("R4 cleared", 5'h0C, 5, 1'b0);
    endtask

    task automatic t_level;
        edg_v[8] = 1'b0; edg_v[9] = 1'b0;
        wr(5'h18, edg_v);
        tick(2);
        chk_bit("R5 high-level idle", 5'h0C, 8, 1'b0);
        pol_v[9] = 1'b0;
        wr(5'h14, pol_v);
        tick(1);
        chk_bit("R5 low-level active", 5'h0C, 9, 1'b1);
        pins[9] = 1'b1;
        tick(3);
        chk_bit("R5 low-level drops", 5'h0C, 9, 1'b0);
        pins[8] = 1'b1;
        tick(3);
        chk_bit("R5 high-level active", 5'h0C, 8, 1'b1);
        wr(5'h10, 32'h0000_0100);
        chk_bit("R7 cleared one cycle", 5'h0C, 8, 1'b0);
        tick(1);
        chk_bit("R7 level rearms", 5'h0C, 8, 1'b1);
        pins[8] = 1'b0;
        tick(3);
        chk_bit("R5 high-level drops", 5'h0C, 8, 1'b0);
    endtask

    task automatic t_mask;
        pins[3] = 1'b1;
        tick(3);
        wr(5'h00, 32'h0000_0008);
        chk_bit("R8 raw ignores mask", 5'h0C, 3, 1'b1);
        chk_bit("R8 masked status", 5'h08, 3, 1'b0);
        chk("R8 irq masked", {31'b0, irq[3]}, 32'h0);
        wr(5'h00, 32'h0);
        chk_bit("R8 masked status open", 5'h08, 3, 1'b1);
        chk("R8 irq open", {31'b0, irq[3]}, 32'h1);
        pins[3] = 1'b0;
        wr(5'h10, 32'h0000_0008);
    endtask

    task automatic t_config_change;
        pins[12] = 1'b1;
        tick(3);
        wr(5'h10, 32'h0000_1000);
        chk_bit("R9 baseline cleared", 5'h0C, 12, 1'b0);
        pol_v[12] = 1'b0;
        wr(5'h14, pol_v);
        tick(4);
        chk_bit("R9 to falling no req", 5'h0C, 12, 1'b0);
        edg_v[12] = 1'b0;
        wr(5'h18, edg_v);
        tick(3);
        chk_bit("R9 to low-level no req", 5'h0C, 12, 1'b0);
        edg_v[12] = 1'b1;
        wr(5'h18, edg_v);
        tick(3);
        chk_bit("R9 back to falling no req", 5'h0C, 12, 1'b0);
    endtask

    task automatic t_indep;
        logic [31:0] d;
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h0C, d); chk("R10 all clear", d, 32'h0);
        pins[0] = 1'b1; pins[31] = 1'b1;
        tick(3);
        rd(5'h0C, d); chk("R10 two channels", d, 32'h8000_0001);
        wr(5'h10, 32'h0000_0001);
        rd(5'h0C, d); chk("R10 clear one only", d, 32'h8000_0000);
        chk("R10 irq word", irq, 32'h8000_0000);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=running exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_regs();
        t_rise();
        t_fall();
        t_level();
        t_mask();
        t_config_change();
        t_indep();
        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule